// File: doc/BRIEF.md
# Hot-Swap Bus Link Controller

This block decides when the backplane side and the card side of a two-wire serial bus buffer are allowed to be joined. It receives the raw digital levels of the data and clock lines on both sides, a supply-good flag, a link enable and a stuck-bus fault flag. It produces a connect command for the analog pass stage, a ready flag, and a one-cycle clear pulse for the external stuck-bus timer. All inputs pass through two-stage synchronizers, and all timing is counted in system clock cycles.

A join is made only after a transaction on the backplane side is known to be finished. That is shown by either a STOP (data rising while clock is high) or a quiet interval with no backplane edges. In the same cycle, both card-side lines must read high. A fault or a low enable breaks the link. Reconnection follows the same qualification, with one exception. When enable rises again after a fault has been seen, the link is forced closed at once and the stuck-bus timer is told to restart.

The state machine has six states. `ST_OFF` means supply not good. `ST_HOLD` means enable low. `ST_FAULT` means the fault is active. `ST_QUAL` is waiting for STOP or idle with the card side high. `ST_FORCED` is a one-cycle forced join that pulses the timer clear. `ST_LINK` is joined. The transitions are checked in priority order. Supply low goes to `ST_OFF`, enable low goes to `ST_HOLD`, and fault goes to `ST_FAULT`. An enable rise with the fault memory set goes to `ST_FORCED`. From that point, `ST_OFF`/`ST_HOLD`/`ST_FAULT` go to `ST_QUAL`. `ST_QUAL` goes to `ST_LINK` once it is qualified. `ST_FORCED` goes to `ST_LINK`.

Top module: `hsw_link_ctrl`

## Requirements
- R1: While supply-good is low the link stays open, and backplane STOP or idle activity during that time never causes a join.
- R2: In qualification, a backplane STOP (synchronized data goes 0 to 1 while synchronized clock is 1 in both cycles) closes the link on the third rising edge after the data rise is driven.
- R3: In qualification, IDLE_CYC cycles with no backplane edge close the link. Any backplane data or clock edge restarts that count. With IDLE_CYC=N, the join happens on rising edge N+4 after the last input change is driven.
- R4: A join through qualification needs both card-side lines high. While either is low, the link stays open. Once both read high with the condition met, it closes on the third rising edge.
- R5: The ready output equals the connect output in every cycle.
- R6: Enable low opens the link on the third rising edge after it is driven, and inhibits the forced join until enable rises.
- R7: When enable returns high with no fault remembered, the link closes only after full qualification.
- R8: An enable rise after a fault has been seen closes the link on the third rising edge without qualification. The timer clear output is high for exactly that one cycle.
- R9: Fault high opens the link on the third rising edge. After the fault clears, the join again needs full qualification.
- R10: Every input passes through a two-flop synchronizer. No input change affects the outputs before the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply above lockout threshold |
| en_in | input | 1 | Link enable |
| fault_in | input | 1 | Stuck-bus fault flag |
| in_sda | input | 1 | Backplane data level |
| in_scl | input | 1 | Backplane clock level |
| out_sda | input | 1 | Card data level |
| out_scl | input | 1 | Card clock level |
| link_on | output | 1 | Connect command to the pass stage |
| link_ready | output | 1 | Link status flag |
| tmr_clr | output | 1 | One-cycle restart pulse for the stuck-bus timer |

## Verification
The bench times the idle join to the exact edge, both from a fresh start and after a mid-interval clock edge. A counter that missed restarts would join early, and one that was off by one would miss the edge. It drives a STOP and an idle interval while a card line is held low, which catches a design that joins without the card-side check. It follows a fault with an enable cycle over a bus that cannot qualify. A design without the fault memory would then stay open, and one without the clear pulse, or with a longer pulse, would show a wrong clear output. It also sends STOP traffic while the supply is low, to expose any qualification that leaks through the lockout.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_HOLD   = 3'd1,
        ST_FAULT  = 3'd2,
        ST_QUAL   = 3'd3,
        ST_FORCED = 3'd4,
        ST_LINK   = 3'd5
    } link_st_t;

    localparam int SYN_W   = 7;
    localparam int IX_ISDA = 0;
    localparam int IX_ISCL = 1;
    localparam int IX_OSDA = 2;
    localparam int IX_OSCL = 3;
    localparam int IX_PG   = 4;
    localparam int IX_EN   = 5;
    localparam int IX_FLT  = 6;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hsw_qual_det.sv
module hsw_qual_det #(
    parameter int IDLE_CYC = 23750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sda_s,
    input  logic scl_s,
    output logic stop_hit,
    output logic idle_hit
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYC);

    logic          sda_q;
    logic          scl_q;
    logic [CW-1:0] quiet_cnt;
    logic          any_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_s;
            scl_q <= scl_s;
        end
    end

    assign any_edge = (sda_s != sda_q) || (scl_s != scl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (!arm || any_edge) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != IDLE_MAX) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign stop_hit = arm && sda_s && !sda_q && scl_s && scl_q;
    assign idle_hit = arm && (quiet_cnt == IDLE_MAX);
endmodule

// File: rtl/hsw_link_fsm.sv
module hsw_link_fsm
    import hsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg,
    input  logic en,
    input  logic flt,
    input  logic osda,
    input  logic oscl,
    input  logic stop_hit,
    input  logic idle_hit,
    output logic qual_arm,
    output logic link_on,
    output logic link_ready,
    output logic tmr_clr
);
    link_st_t cur;
    link_st_t nxt;
    logic     en_q;
    logic     flt_mem;
    logic     en_rise;

    assign en_rise = en && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= ST_OFF;
            en_q    <= 1'b0;
            flt_mem <= 1'b0;
        end else begin
            cur  <= nxt;
            en_q <= en;
            if (!pg)
                flt_mem <= 1'b0;
            else if (flt)
                flt_mem <= 1'b1;
            else if (nxt == ST_FORCED || nxt == ST_LINK)
                flt_mem <= 1'b0;
        end
    end

    always_comb begin
        nxt = cur;
        if (!pg) begin
            nxt = ST_OFF;
        end else if (!en) begin
            nxt = ST_HOLD;
        end else if (flt) begin
            nxt = ST_FAULT;
        end else if (en_rise && flt_mem) begin
            nxt = ST_FORCED;
        end else begin
            unique case (cur)
                ST_OFF, ST_HOLD, ST_FAULT: nxt = ST_QUAL;
                ST_QUAL: begin
                    if ((stop_hit || idle_hit) && osda && oscl) nxt = ST_LINK;
                end
                ST_FORCED: nxt = ST_LINK;
                ST_LINK:   nxt = ST_LINK;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    always_comb begin
        qual_arm   = (cur == ST_QUAL);
        link_on    = (cur == ST_LINK) || (cur == ST_FORCED);
        link_ready = link_on;
        tmr_clr    = (cur == ST_FORCED);
    end
endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl
    import hsw_pkg::*;
#(
    parameter int IDLE_CYC = 23750,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic en_in,
    input  logic fault_in,
    input  logic in_sda,
    input  logic in_scl,
    input  logic out_sda,
    input  logic out_scl,
    output logic link_on,
    output logic link_ready,
    output logic tmr_clr
);
    localparam logic [SYN_W-1:0] SYN_RST = 7'b000_1111;

    logic [SYN_W-1:0] raw_v;
    logic [SYN_W-1:0] syn_v;
    logic isda_s, iscl_s, osda_s, oscl_s, pg_s, en_s, flt_s;
    logic qual_arm, stop_hit, idle_hit;

    assign raw_v[IX_ISDA] = in_sda;
    assign raw_v[IX_ISCL] = in_scl;
    assign raw_v[IX_OSDA] = out_sda;
    assign raw_v[IX_OSCL] = out_scl;
    assign raw_v[IX_PG]   = pwr_good;
    assign raw_v[IX_EN]   = en_in;
    assign raw_v[IX_FLT]  = fault_in;

    hsw_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
    );

    assign isda_s = syn_v[IX_ISDA];
    assign iscl_s = syn_v[IX_ISCL];
    assign osda_s = syn_v[IX_OSDA];
    assign oscl_s = syn_v[IX_OSCL];
    assign pg_s   = syn_v[IX_PG];
    assign en_s   = syn_v[IX_EN];
    assign flt_s  = syn_v[IX_FLT];

    hsw_qual_det #(.IDLE_CYC(IDLE_CYC)) u_det (
        .clk(clk), .rst_n(rst_n), .arm(qual_arm),
        .sda_s(isda_s), .scl_s(iscl_s),
        .stop_hit(stop_hit), .idle_hit(idle_hit)
    );

    hsw_link_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pg(pg_s), .en(en_s), .flt(flt_s),
        .osda(osda_s), .oscl(oscl_s),
        .stop_hit(stop_hit), .idle_hit(idle_hit),
        .qual_arm(qual_arm), .link_on(link_on),
        .link_ready(link_ready), .tmr_clr(tmr_clr)
    );
endmodule

// File: rtl/hsw_link_chk.sv
module hsw_link_chk (
    input logic clk,
    input logic rst_n,
    input logic pg_s,
    input logic en_s,
    input logic flt_s,
    input logic osda_s,
    input logic oscl_s,
    input logic link_on,
    input logic link_ready,
    input logic tmr_clr
);
    // R1
    pg_low_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> !link_on);

    // R6
    en_low_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !link_on);

    // R9
    fault_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_s |=> !link_on);

    // R5
    ready_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready == link_on);

    // R4
    card_high_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_on) && !tmr_clr) |-> $past(osda_s && oscl_s));

    // R8
    clr_with_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |-> link_on);

    // R8
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> !tmr_clr);
endmodule

bind hsw_link_ctrl hsw_link_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .en_s(en_s), .flt_s(flt_s),
    .osda_s(osda_s), .oscl_s(oscl_s), .link_on(link_on),
    .link_ready(link_ready), .tmr_clr(tmr_clr)
);

// File: tb/hsw_link_ctrl_bench.sv
module hsw_link_ctrl_bench;
    localparam int IDLE = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, en_in = 1'b0, fault_in = 1'b0;
    logic in_sda = 1'b1, in_scl = 1'b1, out_sda = 1'b1, out_scl = 1'b1;
    logic link_on, link_ready, tmr_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsw_link_ctrl #(.IDLE_CYC(IDLE)) u_hsw_link_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .en_in(en_in),
        .fault_in(fault_in), .in_sda(in_sda), .in_scl(in_scl),
        .out_sda(out_sda), .out_scl(out_scl), .link_on(link_on),
        .link_ready(link_ready), .tmr_clr(tmr_clr)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R5 reset link", link_on, 1'b0);
        check("R5 reset ready", link_ready, 1'b0);
        check("R8 reset clr", tmr_clr, 1'b0);
    endtask

    task automatic t_power();
        @(negedge clk); en_in = 1'b1;
        step(10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); in_sda = 1'b0;
            step(4);
            @(negedge clk); in_sda = 1'b1;
            step(4);
        end
        step(IDLE + 20);
        check("R1 no join while supply low", link_on, 1'b0);
        @(negedge clk); pwr_good = 1'b1;
        step(IDLE + 3);
        check("R3 idle not yet", link_on, 1'b0);
        step(1);
        check("R3 idle join edge", link_on, 1'b1);
        check("R5 ready while linked", link_ready, 1'b1);
    endtask

    task automatic t_enable_drop();
        @(negedge clk); en_in = 1'b0;
        step(2);
        check("R10 no early break", link_on, 1'b1);
        step(1);
        check("R6 enable low opens", link_on, 1'b0);
        check("R5 ready drops", link_ready, 1'b0);
    endtask

    task automatic t_stop();
        @(negedge clk); in_sda = 1'b0;
        step(5);
        @(negedge clk); en_in = 1'b1;
        step(13);
        check("R7 no join without qualify", link_on, 1'b0);
        @(negedge clk); in_sda = 1'b1;
        step(2);
        check("R2 stop not yet", link_on, 1'b0);
        step(1);
        check("R2 stop join", link_on, 1'b1);
    endtask

    task automatic t_card_low();
        @(negedge clk); en_in = 1'b0; out_scl = 1'b0;
        step(6);
        @(negedge clk); en_in = 1'b1;
        step(10);
        @(negedge clk); in_sda = 1'b0;
        step(4);
        @(negedge clk); in_sda = 1'b1;
        step(6);
        check("R4 stop with card low", link_on, 1'b0);
        step(IDLE + 20);
        check("R4 idle with card low", link_on, 1'b0);
        @(negedge clk); out_scl = 1'b1;
        step(2);
        check("R4 card release not yet", link_on, 1'b0);
        step(1);
        check("R4 card release join", link_on, 1'b1);
    endtask

    task automatic t_idle_restart();
        @(negedge clk); en_in = 1'b0;
        step(6);
        @(negedge clk); en_in = 1'b1;
        step(3 + IDLE / 2);
        @(negedge clk); in_scl = 1'b0;
        step(4);
        @(negedge clk); in_scl = 1'b1;
        step(IDLE + 3);
        check("R3 restart not yet", link_on, 1'b0);
        step(1);
        check("R3 restart join", link_on, 1'b1);
    endtask

    task automatic t_fault();
        @(negedge clk); fault_in = 1'b1;
        step(2);
        check("R10 fault not early", link_on, 1'b1);
        step(1);
        check("R9 fault opens", link_on, 1'b0);
        step(5);
        @(negedge clk); fault_in = 1'b0;
        step(IDLE + 3);
        check("R9 requalify not yet", link_on, 1'b0);
        step(1);
        check("R9 requalify join", link_on, 1'b1);
    endtask

    task automatic t_forced();
        @(negedge clk); fault_in = 1'b1;
        step(5);
        @(negedge clk); en_in = 1'b0;
        step(5);
        @(negedge clk); fault_in = 1'b0;
        step(5);
        @(negedge clk); in_sda = 1'b0; out_scl = 1'b0;
        step(5);
        check("R6 stays open with enable low", link_on, 1'b0);
        @(negedge clk); en_in = 1'b1;
        step(2);
        check("R8 forced not yet", link_on, 1'b0);
        check("R8 clr not yet", tmr_clr, 1'b0);
        step(1);
        check("R8 forced join", link_on, 1'b1);
        check("R8 clr pulse", tmr_clr, 1'b1);
        step(1);
        check("R8 clr one cycle", tmr_clr, 1'b0);
        check("R8 link held", link_on, 1'b1);
        @(negedge clk); en_in = 1'b0; out_scl = 1'b1;
        step(6);
        @(negedge clk); en_in = 1'b1;
        step(12);
        check("R7 no second force", link_on, 1'b0);
        check("R7 no clr", tmr_clr, 1'b0);
        @(negedge clk); in_sda = 1'b1;
        step(3);
        check("R7 stop rejoin", link_on, 1'b1);
    endtask

    initial begin
        step(5);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        step(2);
        t_reset();
        t_power();
        t_enable_drop();
        t_stop();
        t_card_low();
        t_idle_restart();
        t_fault();
        t_forced();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule